// File: doc/BRIEF.md
# JTAG Nonvolatile Array Programming Controller

This block sits behind an IEEE 1149.1 TAP controller and turns the instruction held there into actions on a small nonvolatile logic array. The TAP supplies one strobe per state of interest (Test-Logic-Reset, Capture-DR, Shift-DR, Update-DR, Update-IR, Run-Test-Idle) in the TCK domain, with TDI and the 8-bit instruction. The block selects the matching data register between TDI and TDO. It keeps a column address and a column data word, and commits writes to a 16 x 32 register file that stands in for the memory cells.

A host uses it in a fixed order. It enables programming mode, shifts an address and a data word, selects a program instruction and waits in Run-Test-Idle. The write lands on the second TCK edge of that stay. To read back, the host discharges, selects verify, and shifts the data register out. A one-time security fuse blanks all read-back once set. The instructions that touch the array raise a tristate control for the device outputs.

Top module: `jtag_array_prog`

## Requirements
- R1: After reset, and in the cycle after any Test-Logic-Reset strobe, the active instruction is IDCODE (opcode 0x16), programming mode is cleared and the tristate control is low.
- R2: With IDCODE active, Capture-DR loads the 32-bit word {part number[19:0] = 0x0A3C5, manufacturer code[10:0] = 0x2B7, 1'b1}. Shift-DR moves it out on TDO LSB first, with TDI entering at the MSB.
- R3: Address shift (opcode 0x01) selects a 4-bit register. Capture-DR loads the current column address, Shift-DR shifts LSB first, and Update-DR writes the shifted value to the column address.
- R4: Data shift (opcode 0x02) shifts the 32-bit column data register directly, LSB first, with no capture load. After 32 shifts the register holds the shifted-in word.
- R5: Column program (opcode 0x07) writes the data register to the current column on the second TCK rising edge of a Run-Test-Idle stay. There is one write per stay, and the edge count restarts when Run-Test-Idle is left or on Update-IR.
- R6: Program enable (0x28) sets programming mode and program disable (0x1E) clears it, both at Update-IR. Without programming mode, column, increment and fuse programming write nothing.
- R7: Verify (opcode 0x08) loads the addressed column into the data register on the first Run-Test-Idle edge and pulses the read strobe. The word is then shifted out under data shift.
- R8: Init-address (opcode 0x2B) clears the column address on the first Run-Test-Idle edge. Increment program (opcode 0x2A) writes like R5, then advances the address modulo 16.
- R9: Fuse program (opcode 0x09) sets the security fuse on the second Run-Test-Idle edge under programming mode. Once it is set, verify loads all zeros.
- R10: After any committed write, verify neither reads nor pulses the read strobe. Read-back is restored by discharge (opcode 0x14) on its first Run-Test-Idle edge.
- R11: The tristate control is high while address shift, data shift, column program, fuse program, verify or discharge is active, and low for every other instruction.
- R12: BYPASS (0xFF) and every unassigned opcode select a 1-bit register that captures 0 and delays TDI by one shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tlr_i | input | 1 | TAP in Test-Logic-Reset |
| capture_dr_i | input | 1 | TAP in Capture-DR |
| shift_dr_i | input | 1 | TAP in Shift-DR |
| update_dr_i | input | 1 | TAP in Update-DR |
| update_ir_i | input | 1 | TAP in Update-IR |
| rti_i | input | 1 | TAP in Run-Test-Idle |
| tdi_i | input | 1 | Serial data in |
| ir_i | input | 8 | Instruction register contents |
| tdo_o | output | 1 | Serial data out, LSB of selected register |
| addr_o | output | 4 | Column address register |
| data_o | output | 32 | Column data register |
| fuse_o | output | 1 | Security fuse state |
| wr_o | output | 1 | Array write strobe, commits at the next TCK edge |
| rd_o | output | 1 | Array read strobe, loads at the next TCK edge |
| outputs_hiz_o | output | 1 | Device output tristate control |
| prog_mode_o | output | 1 | Programming mode flag |

## Verification
The bench builds the block with its default parameters: a 4-bit address and therefore 16 columns, 32-bit data, and the default identification fields. The narrow address lets seventeen increment-program writes cross the modulo-16 wrap, and the bench then reads back both the overwritten first column and the second column. Random column writes and verifies follow, with long Run-Test-Idle stays that must still give exactly one write on the second edge. After that, the bench checks ignored programming without mode, blocked reads before discharge, and zeroed read-back after the fuse.

// File: rtl/jap_pkg.sv
package jap_pkg;
  localparam int IR_W = 8;

  localparam logic [IR_W-1:0] OP_ADDR      = 8'h01;
  localparam logic [IR_W-1:0] OP_DATA      = 8'h02;
  localparam logic [IR_W-1:0] OP_PROGRAM   = 8'h07;
  localparam logic [IR_W-1:0] OP_VERIFY    = 8'h08;
  localparam logic [IR_W-1:0] OP_FUSE      = 8'h09;
  localparam logic [IR_W-1:0] OP_DISCHARGE = 8'h14;
  localparam logic [IR_W-1:0] OP_IDCODE    = 8'h16;
  localparam logic [IR_W-1:0] OP_PROG_DIS  = 8'h1E;
  localparam logic [IR_W-1:0] OP_PROG_EN   = 8'h28;
  localparam logic [IR_W-1:0] OP_PROG_INCR = 8'h2A;
  localparam logic [IR_W-1:0] OP_INIT_ADDR = 8'h2B;
  localparam logic [IR_W-1:0] OP_BYPASS    = 8'hFF;

  typedef enum logic [1:0] {DR_ID, DR_BYP, DR_ADDR, DR_DATA} dr_sel_e;

  typedef struct packed {
    logic col_prog;
    logic incr_prog;
    logic fuse_prog;
    logic verify;
    logic init_addr;
    logic discharge;
  } op_flags_t;
endpackage

// File: rtl/jap_ir_decode.sv
module jap_ir_decode
  import jap_pkg::*;
(
  input  logic            tck_i,
  input  logic            rst_ni,
  input  logic            tlr_i,
  input  logic            update_ir_i,
  input  logic [IR_W-1:0] ir_i,
  output dr_sel_e         dr_sel_o,
  output op_flags_t       flags_o,
  output logic            hiz_o,
  output logic            prog_mode_o
);
  logic [IR_W-1:0] act_q;
  logic            mode_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= OP_IDCODE;
      mode_q <= 1'b0;
    end else if (tlr_i) begin
      act_q  <= OP_IDCODE;
      mode_q <= 1'b0;
    end else if (update_ir_i) begin
      act_q <= ir_i;
      if (ir_i == OP_PROG_EN)       mode_q <= 1'b1;
      else if (ir_i == OP_PROG_DIS) mode_q <= 1'b0;
    end
  end

  always_comb begin
    dr_sel_o = DR_BYP;
    flags_o  = '0;
    hiz_o    = 1'b0;
    case (act_q)
      OP_IDCODE:    dr_sel_o = DR_ID;
      OP_ADDR:      begin dr_sel_o = DR_ADDR; hiz_o = 1'b1; end
      OP_DATA:      begin dr_sel_o = DR_DATA; hiz_o = 1'b1; end
      OP_VERIFY:    begin dr_sel_o = DR_DATA; hiz_o = 1'b1; flags_o.verify = 1'b1; end
      OP_PROGRAM:   begin hiz_o = 1'b1; flags_o.col_prog = 1'b1; end
      OP_FUSE:      begin hiz_o = 1'b1; flags_o.fuse_prog = 1'b1; end
      OP_DISCHARGE: begin hiz_o = 1'b1; flags_o.discharge = 1'b1; end
      OP_PROG_INCR: flags_o.incr_prog = 1'b1;
      OP_INIT_ADDR: flags_o.init_addr = 1'b1;
      default:      dr_sel_o = DR_BYP;
    endcase
  end

  assign prog_mode_o = mode_q;
endmodule

// File: rtl/jap_rti_timer.sv
module jap_rti_timer #(
  parameter int CNT_W = 2
) (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic rti_i,
  input  logic update_ir_i,
  output logic first_o,
  output logic second_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!rti_i || update_ir_i) cnt_q <= '0;
    else if (cnt_q != CNT_MAX)     cnt_q <= cnt_q + 1'b1;
  end

  // edge index within the stay is cnt_q + 1
  assign first_o  = rti_i && !update_ir_i && (cnt_q == CNT_W'(0));
  assign second_o = rti_i && !update_ir_i && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/jap_dr_path.sv
module jap_dr_path
  import jap_pkg::*;
#(
  parameter int          ADDR_W  = 4,
  parameter int          DATA_W  = 32,
  parameter logic [31:0] ID_WORD = 32'h1
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  dr_sel_e           dr_sel_i,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic              update_i,
  input  logic              tdi_i,
  input  logic              addr_clr_i,
  input  logic              addr_inc_i,
  input  logic              data_ld_i,
  input  logic [DATA_W-1:0] data_ld_val_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              tdo_o
);
  logic [31:0]       id_sr;
  logic              byp_q;
  logic [ADDR_W-1:0] addr_sr, addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) id_sr <= ID_WORD;
    else if (dr_sel_i == DR_ID) begin
      if (capture_i)    id_sr <= ID_WORD;
      else if (shift_i) id_sr <= {tdi_i, id_sr[31:1]};
    end
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) byp_q <= 1'b0;
    else if (dr_sel_i == DR_BYP) begin
      if (capture_i)    byp_q <= 1'b0;
      else if (shift_i) byp_q <= tdi_i;
    end
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) addr_sr <= '0;
    else if (dr_sel_i == DR_ADDR) begin
      if (capture_i)    addr_sr <= addr_q;
      else if (shift_i) addr_sr <= {tdi_i, addr_sr[ADDR_W-1:1]};
    end
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                              addr_q <= '0;
    else if (update_i && dr_sel_i == DR_ADDR) addr_q <= addr_sr;
    else if (addr_clr_i)                      addr_q <= '0;
    else if (addr_inc_i)                      addr_q <= addr_q + 1'b1;
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                             data_q <= '0;
    else if (shift_i && dr_sel_i == DR_DATA) data_q <= {tdi_i, data_q[DATA_W-1:1]};
    else if (data_ld_i)                      data_q <= data_ld_val_i;
  end

  always_comb begin
    case (dr_sel_i)
      DR_ID:   tdo_o = id_sr[0];
      DR_ADDR: tdo_o = addr_sr[0];
      DR_DATA: tdo_o = data_q[0];
      default: tdo_o = byp_q;
    endcase
  end

  assign addr_o = addr_q;
  assign data_o = data_q;
endmodule

// File: rtl/jap_array.sv
module jap_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              fuse_wr_i,
  input  logic              discharge_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              fuse_o,
  output logic              ready_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              fuse_q, ready_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_col
    always_ff @(posedge tck_i or negedge rst_ni) begin
      if (!rst_ni)                               mem_q[g] <= '0;
      else if (wr_i && addr_i == ADDR_W'(g))     mem_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fuse_q  <= 1'b0;
      ready_q <= 1'b1;
    end else begin
      if (fuse_wr_i) fuse_q <= 1'b1;
      if (wr_i || fuse_wr_i) ready_q <= 1'b0;
      else if (discharge_i)  ready_q <= 1'b1;
    end
  end

  assign rdata_o = fuse_q ? '0 : mem_q[addr_i];
  assign fuse_o  = fuse_q;
  assign ready_o = ready_q;
endmodule

// File: rtl/jtag_array_prog.sv
module jtag_array_prog
  import jap_pkg::*;
#(
  parameter int          ADDR_W  = 4,
  parameter int          DATA_W  = 32,
  parameter logic [19:0] PART_ID = 20'h0A3C5,
  parameter logic [10:0] MFR_ID  = 11'h2B7
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              tlr_i,
  input  logic              capture_dr_i,
  input  logic              shift_dr_i,
  input  logic              update_dr_i,
  input  logic              update_ir_i,
  input  logic              rti_i,
  input  logic              tdi_i,
  input  logic [IR_W-1:0]   ir_i,
  output logic              tdo_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              fuse_o,
  output logic              wr_o,
  output logic              rd_o,
  output logic              outputs_hiz_o,
  output logic              prog_mode_o
);
  localparam logic [31:0] ID_WORD = {PART_ID, MFR_ID, 1'b1};

  dr_sel_e           dr_sel;
  op_flags_t         flags;
  logic              first_edge, second_edge;
  logic              col_wr, incr_wr, fuse_wr, rd_en;
  logic              ready;
  logic [DATA_W-1:0] rdata;

  jap_ir_decode i_decode (
    .tck_i       (tck_i),
    .rst_ni      (rst_ni),
    .tlr_i       (tlr_i),
    .update_ir_i (update_ir_i),
    .ir_i        (ir_i),
    .dr_sel_o    (dr_sel),
    .flags_o     (flags),
    .hiz_o       (outputs_hiz_o),
    .prog_mode_o (prog_mode_o)
  );

  jap_rti_timer #(.CNT_W(2)) i_timer (
    .tck_i       (tck_i),
    .rst_ni      (rst_ni),
    .rti_i       (rti_i),
    .update_ir_i (update_ir_i),
    .first_o     (first_edge),
    .second_o    (second_edge)
  );

  assign col_wr  = prog_mode_o && second_edge && flags.col_prog;
  assign incr_wr = prog_mode_o && second_edge && flags.incr_prog;
  assign fuse_wr = prog_mode_o && second_edge && flags.fuse_prog;
  assign rd_en   = first_edge && flags.verify && ready;
  assign wr_o    = col_wr || incr_wr;
  assign rd_o    = rd_en;

  jap_dr_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_WORD(ID_WORD)) i_dr (
    .tck_i         (tck_i),
    .rst_ni        (rst_ni),
    .dr_sel_i      (dr_sel),
    .capture_i     (capture_dr_i),
    .shift_i       (shift_dr_i),
    .update_i      (update_dr_i),
    .tdi_i         (tdi_i),
    .addr_clr_i    (first_edge && flags.init_addr),
    .addr_inc_i    (incr_wr),
    .data_ld_i     (rd_en),
    .data_ld_val_i (rdata),
    .addr_o        (addr_o),
    .data_o        (data_o),
    .tdo_o         (tdo_o)
  );

  jap_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_array (
    .tck_i       (tck_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_o),
    .fuse_wr_i   (fuse_wr),
    .discharge_i (first_edge && flags.discharge),
    .addr_i      (addr_o),
    .wdata_i     (data_o),
    .rdata_o     (rdata),
    .fuse_o      (fuse_o),
    .ready_o     (ready)
  );
endmodule

// File: rtl/jap_checker.sv
module jap_checker #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              tck_i,
  input logic              rst_ni,
  input logic              tlr_i,
  input logic              rti_i,
  input logic              wr_o,
  input logic              rd_o,
  input logic              incr_wr,
  input logic              prog_mode_o,
  input logic              outputs_hiz_o,
  input logic              fuse_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [DATA_W-1:0] data_o
);
  assert_tlr_idle_R1: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tlr_i |=> (!prog_mode_o && !outputs_hiz_o));

  assert_wr_in_rti_R5: assert property (@(posedge tck_i) disable iff (!rst_ni)
    wr_o |-> rti_i);

  assert_single_wr_R5: assert property (@(posedge tck_i) disable iff (!rst_ni)
    wr_o |=> !wr_o);

  assert_wr_needs_mode_R6: assert property (@(posedge tck_i) disable iff (!rst_ni)
    wr_o |-> prog_mode_o);

  assert_incr_wrap_R8: assert property (@(posedge tck_i) disable iff (!rst_ni)
    incr_wr |=> (addr_o == ADDR_W'($past(addr_o) + 1'b1)));

  assert_fused_read_zero_R9: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (rd_o && fuse_o) |=> (data_o == '0));
endmodule

bind jtag_array_prog jap_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .tck_i         (tck_i),
  .rst_ni        (rst_ni),
  .tlr_i         (tlr_i),
  .rti_i         (rti_i),
  .wr_o          (wr_o),
  .rd_o          (rd_o),
  .incr_wr       (incr_wr),
  .prog_mode_o   (prog_mode_o),
  .outputs_hiz_o (outputs_hiz_o),
  .fuse_o        (fuse_o),
  .addr_o        (addr_o),
  .data_o        (data_o)
);

// File: tb/test_jtag_array_prog.sv
module test_jtag_array_prog;
  localparam int CLK_PERIOD = 10;

  localparam logic [7:0] C_ADDR = 8'h01, C_DATA = 8'h02, C_PROG = 8'h07,
    C_VER = 8'h08, C_FUSE = 8'h09, C_DIS = 8'h14, C_ID = 8'h16, C_PDIS = 8'h1E,
    C_PEN = 8'h28, C_INCR = 8'h2A, C_INIT = 8'h2B, C_BYP = 8'hFF;
  localparam logic [31:0] EXP_ID = {20'h0A3C5, 11'h2B7, 1'b1};

  logic tck = 1'b0, rst_ni = 1'b0;
  logic tlr = 0, cap = 0, shf = 0, upd = 0, uir = 0, rti = 0, tdi = 0;
  logic [7:0]  ir = 8'h00;
  logic        tdo, fuse, wr, rd, hiz, pmode;
  logic [3:0]  addr;
  logic [31:0] data;

  int n_chk = 0, n_fail = 0;
  int wr_cnt, rd_cnt, wr_edge;
  logic [31:0] mem_m [16];
  bit mode_m = 0, fuse_m = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) tck = ~tck;

  jtag_array_prog i_jtag_array_prog (
    .tck_i(tck), .rst_ni(rst_ni), .tlr_i(tlr), .capture_dr_i(cap),
    .shift_dr_i(shf), .update_dr_i(upd), .update_ir_i(uir), .rti_i(rti),
    .tdi_i(tdi), .ir_i(ir), .tdo_o(tdo), .addr_o(addr), .data_o(data),
    .fuse_o(fuse), .wr_o(wr), .rd_o(rd), .outputs_hiz_o(hiz), .prog_mode_o(pmode)
  );

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    return fuse_m ? 32'h0 : mem_m[a];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge tck);
    @(negedge tck);
  endtask

  task automatic load_ir(input logic [7:0] op);
    ir = op; uir = 1; step(); uir = 0;
  endtask

  task automatic scan(input int n, input logic [31:0] din, output logic [31:0] dout);
    cap = 1; step(); cap = 0;
    shf = 1; dout = '0;
    for (int i = 0; i < n; i++) begin
      tdi = din[i]; #1 dout[i] = tdo; step();
    end
    shf = 0; upd = 1; step(); upd = 0;
  endtask

  task automatic run_idle(input int n);
    wr_cnt = 0; rd_cnt = 0; wr_edge = 0;
    rti = 1;
    for (int i = 0; i < n; i++) begin
      #1;
      if (wr) begin wr_cnt++; wr_edge = i + 1; end
      if (rd) rd_cnt++;
      step();
    end
    rti = 0; step();
  endtask

  task automatic write_col(input logic [3:0] a, input logic [31:0] d);
    logic [31:0] o;
    load_ir(C_ADDR); scan(4, {28'h0, a}, o);
    load_ir(C_DATA); scan(32, d, o);
    load_ir(C_PROG); run_idle(2);
    if (mode_m) mem_m[a] = d;
  endtask

  task automatic read_col(input logic [3:0] a, output logic [31:0] o);
    logic [31:0] junk;
    load_ir(C_DIS); run_idle(1);
    load_ir(C_ADDR); scan(4, {28'h0, a}, junk);
    load_ir(C_DATA); scan(32, 32'hDEAD_BEEF, junk);
    load_ir(C_VER); run_idle(1);
    load_ir(C_DATA); scan(32, 32'h0, o);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %h expected %h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] o, d;
    logic [3:0]  a;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 16; i++) mem_m[i] = '0;
    step(); step(); rst_ni = 1; step();

    // R1 reset state, R2 ID layout
    check(!pmode && !hiz && !fuse, "R1 reset state", {29'h0, pmode, hiz, fuse}, 32'h0);
    scan(32, 32'h1234_5678, o);
    check(o == EXP_ID, "R2 idcode after reset", o, EXP_ID);

    // R3 address shift and R11 tristate
    load_ir(C_ADDR);
    check(hiz, "R11 hiz for address shift", {31'h0, hiz}, 32'h1);
    scan(4, 32'h5, o);
    check(o[3:0] == 4'h0, "R3 capture old address", {28'h0, o[3:0]}, 32'h0);
    check(addr == 4'h5, "R3 address update", {28'h0, addr}, 32'h5);
    scan(4, 32'hA, o);
    check(o[3:0] == 4'h5, "R3 capture current address", {28'h0, o[3:0]}, 32'h5);

    // R4 data shift
    load_ir(C_DATA);
    scan(32, 32'hA5A5_1234, o);
    check(data == 32'hA5A5_1234, "R4 data register load", data, 32'hA5A5_1234);
    check(hiz, "R11 hiz for data shift", {31'h0, hiz}, 32'h1);

    // R6 no program without mode
    load_ir(C_PROG); run_idle(4);
    check(wr_cnt == 0, "R6 program ignored without mode", wr_cnt, 0);
    check(!pmode, "R6 mode off", {31'h0, pmode}, 32'h0);

    // R5 second edge commit
    load_ir(C_PEN); mode_m = 1;
    check(pmode, "R6 program enable", {31'h0, pmode}, 32'h1);
    check(!hiz, "R11 no hiz for program enable", {31'h0, hiz}, 32'h0);
    load_ir(C_PROG); run_idle(1);
    check(wr_cnt == 0, "R5 no write on first edge", wr_cnt, 0);
    run_idle(6);
    check(wr_cnt == 1 && wr_edge == 2, "R5 one write on second edge", {wr_cnt[15:0], wr_edge[15:0]}, {16'd1, 16'd2});
    mem_m[10] = 32'hA5A5_1234; // address A from last address scan

    // R10 verify blocked before discharge
    load_ir(C_DATA); scan(32, 32'h0BAD_0BAD, o);
    load_ir(C_VER); run_idle(2);
    check(rd_cnt == 0, "R10 verify blocked after write", rd_cnt, 0);
    check(data == 32'h0BAD_0BAD, "R10 data kept when blocked", data, 32'h0BAD_0BAD);
    load_ir(C_DIS); run_idle(1);
    load_ir(C_VER); run_idle(1);
    check(rd_cnt == 1, "R10 verify restored by discharge", rd_cnt, 1);
    check(data == mem_m[10], "R7 verify loads column", data, mem_m[10]);

    // R8 init + increment program across wrap
    load_ir(C_INIT); run_idle(1);
    check(addr == 4'h0, "R8 init clears address", {28'h0, addr}, 32'h0);
    for (int k = 0; k < 17; k++) begin
      d = $urandom();
      load_ir(C_DATA); scan(32, d, o);
      load_ir(C_INCR); run_idle(2);
      mem_m[k % 16] = d;
    end
    check(addr == 4'h1, "R8 address wraps modulo 16", {28'h0, addr}, 32'h1);
    read_col(4'h0, o);
    check(o == exp_read(4'h0), "R8 wrapped column overwritten", o, exp_read(4'h0));
    read_col(4'h1, o);
    check(o == exp_read(4'h1), "R8 second column", o, exp_read(4'h1));

    // R7 random writes and verifies
    for (int k = 0; k < 20; k++) begin
      a = 4'($urandom());
      d = $urandom();
      write_col(a, d);
      a = 4'($urandom());
      read_col(a, o);
      check(o == exp_read(a), "R7 random verify", o, exp_read(a));
    end

    // R12 bypass and unassigned opcode
    load_ir(C_BYP);
    scan(2, 32'h1, o);
    check(o[1:0] == 2'b10, "R12 bypass delay", {30'h0, o[1:0]}, 32'h2);
    check(!hiz, "R11 no hiz for bypass", {31'h0, hiz}, 32'h0);
    load_ir(8'h55);
    scan(2, 32'h0, o);
    check(o[1:0] == 2'b00, "R12 unassigned acts as bypass", {30'h0, o[1:0]}, 32'h0);

    // R6 program disable
    load_ir(C_PDIS); mode_m = 0;
    check(!pmode, "R6 program disable", {31'h0, pmode}, 32'h0);
    write_col(4'h3, 32'hFFFF_0000);
    read_col(4'h3, o);
    check(o == exp_read(4'h3), "R6 write ignored after disable", o, exp_read(4'h3));

    // R1 test-logic-reset
    load_ir(C_PEN); mode_m = 1;
    load_ir(C_ADDR);
    tlr = 1; step(); tlr = 0;
    check(!pmode && !hiz, "R1 tlr clears mode and hiz", {30'h0, pmode, hiz}, 32'h0);
    scan(32, 32'h0, o);
    check(o == EXP_ID, "R1 idcode after tlr", o, EXP_ID);
    mode_m = 0;

    // R9 fuse
    load_ir(C_FUSE); run_idle(3);
    check(!fuse, "R9 fuse ignored without mode", {31'h0, fuse}, 32'h0);
    load_ir(C_PEN); mode_m = 1;
    load_ir(C_FUSE); run_idle(1);
    check(!fuse, "R9 fuse not set on first edge", {31'h0, fuse}, 32'h0);
    run_idle(2);
    check(fuse, "R9 fuse set on second edge", {31'h0, fuse}, 32'h1);
    fuse_m = 1;
    read_col(4'hA, o);
    check(o == 32'h0, "R9 fused read returns zero", o, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule